// File: doc/BRIEF.md
# Privileged Control-Register Access Unit

This block carries out the three control-register instructions of a small processor core: read, write and masked exchange. It sits between the register-file ports and a local bank of control registers. One request per cycle comes in with a strobe, an opcode, a 14-bit register number, a source value, a mask value and the current privilege level. One cycle later the block returns the value for the destination register, together with a done pulse and three status strobes: a privilege exception, an illegal-instruction trap and a pipeline-flush request.

The bank has several kinds of register:
- **Plain writable registers.** Some of them are mode-affecting, and a successful write to one of them requests a flush.
- **Read-only registers.** These are the core index and a configuration word.
- **Sixteen scratch save registers.**
- **Four direct-map window registers.**

Any register number that the bank does not implement reads as zero. Writes to such a number are dropped.

A two-state machine sequences each response:
- **ST_IDLE** means no response is pending.
- **ST_RESP** means the registered response is on the outputs and `rsp_done` is high.

The transitions are:
- **ACCEPT** (ST_IDLE to ST_RESP) on a strobe.
- **STREAM** (ST_RESP to ST_RESP) on a strobe while a response is being shown, so requests can arrive back-to-back.
- **RETIRE** (ST_RESP to ST_IDLE) when no strobe arrives.

Top module: `csr_access_unit`

## Requirements
- R1: The response for a request with `req_valid` high at clock edge k appears after edge k and is held until edge k+1. `rsp_done` is high exactly in those cycles. The strobes `rsp_priv_exc`, `rsp_ill_trap` and `rsp_flush` are never high without `rsp_done`.
- R2: A request with `cur_priv` = 3 (user level) raises `rsp_priv_exc` and returns 0. It raises neither trap nor flush and changes no register.
- R3: A read (opcode 0) returns the current contents of the register. Number 0x020 is read-only and returns the `CORE_IDX` parameter zero-extended to the data width. Number 0x021 is read-only and returns `CFG_WORD`.
- R4: A read of any number with no register behind it returns 0. Examples are 0x007, 0x040, 0x184 and 0x3FFF.
- R5: A write or exchange to an unimplemented number returns 0, raises no trap and modifies no register.
- R6: A write or exchange to 0x020 or 0x021 raises `rsp_ill_trap`, returns 0 and leaves the register unchanged.
- R7: A write (opcode 1) returns the old contents and stores the source value.
- R8: An exchange (opcode 2) stores (src AND mask) OR (old AND NOT mask) and returns the old contents.
- R9: A write or exchange to the mode register 0x000, unit enable 0x002, exception status 0x005 or address-space ID 0x018 raises `rsp_flush`. Reads never raise it. Writes to the other registers (0x001, 0x006, save and window registers) do not raise it.
- R10: Save registers 0x030 to 0x03F and window registers 0x180 to 0x183 each hold an independent value.
- R11: After reset the mode register 0x000 holds `MODE_RST` (0 by default, the most privileged level). All other writable registers, including all save registers, hold 0. No response is pending after reset.
- R12: Opcode 3 at a privileged level raises `rsp_ill_trap`, returns 0 and changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | 0 read, 1 write, 2 exchange, 3 reserved |
| req_num | input | 14 | Control register number |
| req_src | input | XLEN | Source value |
| req_mask | input | XLEN | Exchange mask |
| cur_priv | input | 2 | Current privilege level, 0 highest, 3 user |
| rsp_done | output | 1 | Response valid |
| rsp_data | output | XLEN | Value for the destination register |
| rsp_priv_exc | output | 1 | Privilege-instruction exception |
| rsp_ill_trap | output | 1 | Illegal-instruction trap |
| rsp_flush | output | 1 | Pipeline flush request |

## Verification
Every result is due exactly one cycle after the edge that sampled its strobe. Register updates are visible to a request issued in the very next cycle.

The bench stamps each expected item with the cycle in which it was issued. On a negative edge it pops an item when `rsp_done` is high and checks that the current cycle is the issue cycle plus one. If an item's due cycle passes with no `rsp_done`, the bench reports it as missing.

Back-to-back requests to the same register check that a write lands in time for the following request.

// File: rtl/csr_pkg.sv
package csr_pkg;

    localparam int NUM_W = 14;

    typedef enum logic [1:0] {
        OP_RD   = 2'd0,
        OP_WR   = 2'd1,
        OP_XCHG = 2'd2,
        OP_RSVD = 2'd3
    } csr_op_e;

    typedef enum logic [1:0] {
        KIND_NONE,
        KIND_PLAIN,
        KIND_FLUSH,
        KIND_RO
    } csr_kind_e;

    typedef enum logic {
        ST_IDLE,
        ST_RESP
    } csr_state_e;

    localparam logic [1:0] PRIV_USER = 2'd3;

    localparam logic [NUM_W-1:0] NUM_MODE   = 14'h000;
    localparam logic [NUM_W-1:0] NUM_PREV   = 14'h001;
    localparam logic [NUM_W-1:0] NUM_UNIT   = 14'h002;
    localparam logic [NUM_W-1:0] NUM_EXCST  = 14'h005;
    localparam logic [NUM_W-1:0] NUM_EXCRET = 14'h006;
    localparam logic [NUM_W-1:0] NUM_ASID   = 14'h018;
    localparam logic [NUM_W-1:0] NUM_COREID = 14'h020;
    localparam logic [NUM_W-1:0] NUM_CFG    = 14'h021;
    localparam logic [NUM_W-1:0] NUM_SAVE0  = 14'h030;
    localparam logic [NUM_W-1:0] NUM_WIN0   = 14'h180;

    localparam int N_FIXED     = 6;
    localparam int SLOT_MODE   = 0;
    localparam int SLOT_PREV   = 1;
    localparam int SLOT_UNIT   = 2;
    localparam int SLOT_EXCST  = 3;
    localparam int SLOT_EXCRET = 4;
    localparam int SLOT_ASID   = 5;

endpackage

// File: rtl/csr_decode.sv
module csr_decode
    import csr_pkg::*;
#(
    parameter int          XLEN     = 32,
    parameter int          N_SAVE   = 16,
    parameter int          N_WIN    = 4,
    parameter int          SLOT_W   = 5,
    parameter int          CORE_IDX = 0,
    parameter logic [XLEN-1:0] CFG_WORD = '0
) (
    input  logic [NUM_W-1:0]  num,
    output csr_kind_e         kind,
    output logic [SLOT_W-1:0] slot,
    output logic [XLEN-1:0]   ro_val
);

    localparam logic [NUM_W-1:0] SAVE_END = NUM_SAVE0 + NUM_W'(N_SAVE);
    localparam logic [NUM_W-1:0] WIN_END  = NUM_WIN0 + NUM_W'(N_WIN);
    localparam logic [SLOT_W-1:0] SAVE_BASE = SLOT_W'(N_FIXED);
    localparam logic [SLOT_W-1:0] WIN_BASE  = SLOT_W'(N_FIXED + N_SAVE);

    logic ro_cfg;

    always_comb begin
        kind   = KIND_NONE;
        slot   = '0;
        ro_cfg = 1'b0;
        case (num)
            NUM_MODE:   begin kind = KIND_FLUSH; slot = SLOT_W'(SLOT_MODE);   end
            NUM_PREV:   begin kind = KIND_PLAIN; slot = SLOT_W'(SLOT_PREV);   end
            NUM_UNIT:   begin kind = KIND_FLUSH; slot = SLOT_W'(SLOT_UNIT);   end
            NUM_EXCST:  begin kind = KIND_FLUSH; slot = SLOT_W'(SLOT_EXCST);  end
            NUM_EXCRET: begin kind = KIND_PLAIN; slot = SLOT_W'(SLOT_EXCRET); end
            NUM_ASID:   begin kind = KIND_FLUSH; slot = SLOT_W'(SLOT_ASID);   end
            NUM_COREID: begin kind = KIND_RO; end
            NUM_CFG:    begin kind = KIND_RO; ro_cfg = 1'b1; end
            default: begin
                if (num >= NUM_SAVE0 && num < SAVE_END) begin
                    kind = KIND_PLAIN;
                    slot = SAVE_BASE + SLOT_W'(num - NUM_SAVE0);
                end else if (num >= NUM_WIN0 && num < WIN_END) begin
                    kind = KIND_PLAIN;
                    slot = WIN_BASE + SLOT_W'(num - NUM_WIN0);
                end
            end
        endcase
    end

    assign ro_val = ro_cfg ? CFG_WORD : XLEN'(CORE_IDX);

endmodule

// File: rtl/csr_bank.sv
module csr_bank
    import csr_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter int N_SLOT   = 26,
    parameter int SLOT_W   = 5,
    parameter int MODE_RST = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [XLEN-1:0]   wr_data,
    input  logic [SLOT_W-1:0] rd_slot,
    output logic [XLEN-1:0]   rd_data
);

    logic [XLEN-1:0] slot_q [N_SLOT];

    for (genvar g = 0; g < N_SLOT; g++) begin : g_slot
        localparam logic [XLEN-1:0] RST_VAL = (g == SLOT_MODE) ? XLEN'(MODE_RST) : '0;
        logic [XLEN-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= RST_VAL;
            end else if (wr_en && wr_slot == SLOT_W'(g)) begin
                q <= wr_data;
            end
        end
        assign slot_q[g] = q;
    end

    assign rd_data = ({1'b0, rd_slot} < (SLOT_W + 1)'(N_SLOT)) ? slot_q[rd_slot] : '0;

endmodule

// File: rtl/csr_access_unit.sv
module csr_access_unit
    import csr_pkg::*;
#(
    parameter int              XLEN     = 32,
    parameter int              N_SAVE   = 16,
    parameter int              N_WIN    = 4,
    parameter int              CORE_IDX = 0,
    parameter logic [XLEN-1:0] CFG_WORD = 32'h0000_0A51,
    parameter int              MODE_RST = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [1:0]       req_op,
    input  logic [13:0]      req_num,
    input  logic [XLEN-1:0]  req_src,
    input  logic [XLEN-1:0]  req_mask,
    input  logic [1:0]       cur_priv,
    output logic             rsp_done,
    output logic [XLEN-1:0]  rsp_data,
    output logic             rsp_priv_exc,
    output logic             rsp_ill_trap,
    output logic             rsp_flush
);

    localparam int N_SLOT = N_FIXED + N_SAVE + N_WIN;
    localparam int SLOT_W = $clog2(N_SLOT);

    csr_state_e state_q, state_nx;
    csr_kind_e  kind;
    csr_op_e    op;
    logic [SLOT_W-1:0] slot;
    logic [XLEN-1:0]   ro_val, bank_rd, old_val, merged, wr_data;
    logic [XLEN-1:0]   res_nx;
    logic              exc_nx, trap_nx, flush_nx, wr_ok, wr_en;

    assign op = csr_op_e'(req_op);

    csr_decode #(
        .XLEN(XLEN), .N_SAVE(N_SAVE), .N_WIN(N_WIN), .SLOT_W(SLOT_W),
        .CORE_IDX(CORE_IDX), .CFG_WORD(CFG_WORD)
    ) u_decode (
        .num(req_num), .kind(kind), .slot(slot), .ro_val(ro_val)
    );

    csr_bank #(
        .XLEN(XLEN), .N_SLOT(N_SLOT), .SLOT_W(SLOT_W), .MODE_RST(MODE_RST)
    ) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_slot(slot),
        .wr_data(wr_data), .rd_slot(slot), .rd_data(bank_rd)
    );

    always_comb begin
        unique case (kind)
            KIND_NONE: old_val = '0;
            KIND_RO:   old_val = ro_val;
            default:   old_val = bank_rd;
        endcase
    end

    assign merged = (req_src & req_mask) | (old_val & ~req_mask);

    always_comb begin
        res_nx   = '0;
        exc_nx   = 1'b0;
        trap_nx  = 1'b0;
        flush_nx = 1'b0;
        wr_ok    = 1'b0;
        wr_data  = (op == OP_WR) ? req_src : merged;
        if (cur_priv == PRIV_USER) begin
            exc_nx = 1'b1;
        end else begin
            unique case (op)
                OP_RD: res_nx = old_val;
                OP_WR, OP_XCHG: begin
                    if (kind == KIND_RO) begin
                        trap_nx = 1'b1;
                    end else begin
                        res_nx   = old_val;
                        wr_ok    = (kind != KIND_NONE);
                        flush_nx = (kind == KIND_FLUSH);
                    end
                end
                default: trap_nx = 1'b1;
            endcase
        end
    end

    assign wr_en = req_valid && wr_ok;

    // State register: ACCEPT / STREAM / RETIRE
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_nx = req_valid ? ST_RESP : ST_IDLE;
            ST_RESP: state_nx = req_valid ? ST_RESP : ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    // Output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_data     <= '0;
            rsp_priv_exc <= 1'b0;
            rsp_ill_trap <= 1'b0;
            rsp_flush    <= 1'b0;
        end else if (req_valid) begin
            rsp_data     <= res_nx;
            rsp_priv_exc <= exc_nx;
            rsp_ill_trap <= trap_nx;
            rsp_flush    <= flush_nx;
        end else begin
            rsp_priv_exc <= 1'b0;
            rsp_ill_trap <= 1'b0;
            rsp_flush    <= 1'b0;
        end
    end

    assign rsp_done = (state_q == ST_RESP);

endmodule

// File: rtl/csr_access_chk.sv
module csr_access_chk
    import csr_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter int CORE_IDX = 0
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic [1:0]      req_op,
    input logic [13:0]     req_num,
    input logic [1:0]      cur_priv,
    input logic            rsp_done,
    input logic [XLEN-1:0] rsp_data,
    input logic            rsp_priv_exc,
    input logic            rsp_ill_trap,
    input logic            rsp_flush
);

    logic priv_ok;
    assign priv_ok = req_valid && cur_priv != PRIV_USER;

    AST_DONE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_done); // R1
    AST_NO_STRAY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_done); // R1
    AST_STROBE_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_done |-> !(rsp_priv_exc || rsp_ill_trap || rsp_flush)); // R1
    AST_USER_EXC: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && cur_priv == PRIV_USER |=>
            rsp_priv_exc && rsp_data == '0 && !rsp_ill_trap && !rsp_flush); // R2
    AST_CORE_ID: assert property (@(posedge clk) disable iff (!rst_n)
        priv_ok && req_op == 2'd0 && req_num == NUM_COREID |=>
            rsp_data == XLEN'(CORE_IDX)); // R3
    AST_UNDEF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        priv_ok && req_op == 2'd0 && req_num == 14'h3FFF |=> rsp_data == '0); // R4
    AST_RO_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        priv_ok && (req_op == 2'd1 || req_op == 2'd2) && req_num == NUM_COREID |=>
            rsp_ill_trap && !rsp_flush); // R6
    AST_READ_NO_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_op == 2'd0 |=> !rsp_flush); // R9
    AST_RSVD_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        priv_ok && req_op == 2'd3 |=> rsp_ill_trap && rsp_data == '0); // R12
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> $countones({rsp_priv_exc, rsp_ill_trap, rsp_flush}) <= 1); // R2

endmodule

bind csr_access_unit csr_access_chk #(.XLEN(XLEN), .CORE_IDX(CORE_IDX)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_num(req_num), .cur_priv(cur_priv), .rsp_done(rsp_done),
    .rsp_data(rsp_data), .rsp_priv_exc(rsp_priv_exc),
    .rsp_ill_trap(rsp_ill_trap), .rsp_flush(rsp_flush)
);

// File: tb/test_csr_access_unit.sv
`timescale 1ns/1ps
module test_csr_access_unit;

    localparam int          CORE_ID_V = 5;
    localparam logic [31:0] CFG_V     = 32'h0000_0A51;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = '0;
    logic [13:0] req_num = '0;
    logic [31:0] req_src = '0, req_mask = '0;
    logic [1:0]  cur_priv = '0;
    logic        rsp_done, rsp_priv_exc, rsp_ill_trap, rsp_flush;
    logic [31:0] rsp_data;

    always #10 clk = ~clk;

    csr_access_unit #(.XLEN(32), .CORE_IDX(CORE_ID_V), .CFG_WORD(CFG_V)) i_csr_access_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_num(req_num), .req_src(req_src), .req_mask(req_mask),
        .cur_priv(cur_priv), .rsp_done(rsp_done), .rsp_data(rsp_data),
        .rsp_priv_exc(rsp_priv_exc), .rsp_ill_trap(rsp_ill_trap), .rsp_flush(rsp_flush)
    );

    typedef struct {
        logic [31:0] data;
        logic        exc, trap, flush;
        int          cyc;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    logic [31:0] mdl [int];
    int          checks = 0, errors = 0, cyc = 0;
    bit          finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic bit is_plain(int n);
        return (n == 'h000 || n == 'h001 || n == 'h002 || n == 'h005 || n == 'h006 ||
                n == 'h018 || (n >= 'h030 && n <= 'h03F) || (n >= 'h180 && n <= 'h183));
    endfunction

    function automatic bit is_flush(int n);
        return (n == 'h000 || n == 'h002 || n == 'h005 || n == 'h018);
    endfunction

    task automatic model_reset();
        mdl.delete();
        for (int n = 0; n < 'h200; n++) if (is_plain(n)) mdl[n] = 32'h0;
    endtask

    task automatic issue(input logic [1:0] op, input int num, input logic [31:0] src,
                         input logic [31:0] mask, input logic [1:0] priv, input string tag);
        exp_t e;
        logic [31:0] old;
        @(negedge clk);
        e.data = '0; e.exc = 0; e.trap = 0; e.flush = 0; e.cyc = cyc; e.tag = tag;
        if (priv == 2'd3) e.exc = 1;
        else if (op == 2'd3) e.trap = 1;
        else if (num == 'h020 || num == 'h021) begin
            if (op == 2'd0) e.data = (num == 'h020) ? 32'(CORE_ID_V) : CFG_V;
            else e.trap = 1;
        end else if (is_plain(num)) begin
            old = mdl[num];
            e.data = old;
            if (op == 2'd1) mdl[num] = src;
            if (op == 2'd2) mdl[num] = (src & mask) | (old & ~mask);
            e.flush = (op != 2'd0) && is_flush(num);
        end
        sb.push_back(e);
        req_valid = 1; req_op = op; req_num = 14'(num);
        req_src = src; req_mask = mask; cur_priv = priv;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 0;
        end
    endtask

    task automatic summary();
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (rsp_done) begin
                checks++;
                if (sb.size() == 0) begin
                    errors++;
                    $display("FAIL R1 unexpected done: actual done=1 expected done=0");
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    if (e.cyc + 1 != cyc || rsp_data !== e.data || rsp_priv_exc !== e.exc ||
                        rsp_ill_trap !== e.trap || rsp_flush !== e.flush) begin
                        errors++;
                        $display("FAIL %s: actual data=%h exc=%b trap=%b flush=%b cyc=%0d expected data=%h exc=%b trap=%b flush=%b cyc=%0d",
                                 e.tag, rsp_data, rsp_priv_exc, rsp_ill_trap, rsp_flush, cyc,
                                 e.data, e.exc, e.trap, e.flush, e.cyc + 1);
                    end
                end
            end else if (sb.size() > 0 && sb[0].cyc + 1 <= cyc) begin
                exp_t e;
                e = sb.pop_front();
                checks++; errors++;
                $display("FAIL R1 missing done for %s: actual done=0 expected done=1", e.tag);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL R1 watchdog expired: actual running expected finished");
            summary();
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        checks++; // R11 reset state, R1 no pending response
        if (rsp_done !== 0 || rsp_priv_exc !== 0 || rsp_ill_trap !== 0 || rsp_flush !== 0) begin
            errors++;
            $display("FAIL R11 reset outputs: actual %b%b%b%b expected 0000",
                     rsp_done, rsp_priv_exc, rsp_ill_trap, rsp_flush);
        end
        issue(0, 'h000, 0, 0, 0, "R11 mode reset value");
        issue(0, 'h030, 0, 0, 0, "R11 save0 reset");
        issue(0, 'h03F, 0, 0, 0, "R11 save15 reset");
        idle(2);
        issue(1, 'h000, 32'h1, 0, 0, "R7 R9 write mode");
        issue(0, 'h000, 0, 0, 0, "R3 R9 read mode no flush");
        issue(1, 'h001, 32'hCAFE_0001, 0, 0, "R9 write prev no flush");
        issue(1, 'h006, 32'h1234_5678, 0, 0, "R9 write excret no flush");
        idle(1);
        for (int i = 0; i < 16; i++)
            issue(1, 'h030 + i, 32'hA500_0000 + 32'(i * 17), 0, 1, "R10 R7 write save");
        for (int i = 0; i < 4; i++)
            issue(1, 'h180 + i, 32'h5A00_0F00 + 32'(i), 0, 2, "R10 write window");
        for (int i = 0; i < 16; i++) issue(0, 'h030 + i, 0, 0, 0, "R10 read save");
        for (int i = 0; i < 4; i++) issue(0, 'h180 + i, 0, 0, 0, "R10 read window");
        idle(2);
        issue(2, 'h033, 32'hFFFF_FFFF, 32'h0F0F_0000, 0, "R8 exchange save3");
        issue(0, 'h033, 0, 0, 0, "R8 readback save3");
        issue(2, 'h181, 32'h0000_00FF, 32'h0000_0F0F, 0, "R8 exchange window1");
        issue(0, 'h181, 0, 0, 0, "R8 readback window1");
        issue(2, 'h018, 32'h0000_0123, 32'hFFFF_FFFF, 0, "R9 exchange asid flush");
        issue(2, 'h005, 32'h0000_0004, 32'h0000_000C, 0, "R9 exchange excstatus flush");
        issue(1, 'h002, 32'h3, 0, 0, "R9 write unit flush");
        issue(2, 'h030, 32'h1, 32'h1, 0, "R9 exchange save no flush");
        idle(1);
        issue(0, 'h3FFF, 0, 0, 0, "R4 read 0x3FFF");
        issue(0, 'h007, 0, 0, 0, "R4 read 0x007");
        issue(0, 'h040, 0, 0, 0, "R4 read 0x040");
        issue(0, 'h184, 0, 0, 0, "R4 read 0x184");
        issue(1, 'h040, 32'hDEAD_BEEF, 0, 0, "R5 write undefined");
        issue(2, 'h184, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, "R5 exchange undefined");
        issue(0, 'h03F, 0, 0, 0, "R5 save15 unchanged");
        issue(0, 'h183, 0, 0, 0, "R5 window3 unchanged");
        issue(0, 'h040, 0, 0, 0, "R5 undefined still zero");
        idle(1);
        issue(1, 'h020, 32'hFFFF_FFFF, 0, 0, "R6 write core id traps");
        issue(0, 'h020, 0, 0, 0, "R3 R6 core id unchanged");
        issue(2, 'h021, 32'h0, 32'hFFFF_FFFF, 0, "R6 exchange cfg traps");
        issue(0, 'h021, 0, 0, 0, "R3 R6 cfg unchanged");
        idle(1);
        issue(1, 'h031, 32'h0BAD_0BAD, 0, 3, "R2 user write");
        issue(0, 'h031, 0, 0, 3, "R2 user read");
        issue(2, 'h000, 32'hFF, 32'hFF, 3, "R2 user exchange mode");
        issue(0, 'h031, 0, 0, 0, "R2 save1 unchanged");
        issue(0, 'h000, 0, 0, 0, "R2 mode unchanged");
        issue(3, 'h032, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, "R12 reserved op");
        issue(0, 'h032, 0, 0, 0, "R12 save2 unchanged");
        idle(4);
        checks++;
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL R1 leftover items: actual %0d expected 0", sb.size());
        end
        summary();
    end

endmodule